// File: doc/BRIEF.md
# SD Multi-Block Transfer Sequencer

This block runs one sector read or sector write on an SD card as a sequence of multi-block data commands. It accepts a request made of a start sector, a sector count, a direction, a drive choice and a buffer-alignment flag. It rejects a negative count or an out-of-range request before any command goes out. Otherwise it selects the card and splits the request into chunks. For each chunk it writes the byte count, waits for the card to report the transfer state and issues the multi-block read or write command. It then waits for the data path to finish, waits out the card's programming busy after a write, and sends the stop command. After the last chunk it deselects the card.

Commands leave on the same issue interface that the card initialisation sequencer uses. This is a one-cycle `cmd_valid` with the index, the argument and the flag bits, and the command engine answers with a one-cycle `cmd_done` or `cmd_fail`. When a chunk sees a data error, the block pulses the FIFO reset and the DMA reset together. It waits until both report clear and then repeats the same chunk at the same address. A parameter bounds the number of these repeats. The internal drive hides its first blocks behind a fixed offset. Standard-capacity cards are addressed in bytes and high-capacity cards in sectors.

Top module: `sdx_xfer_seq`

## Requirements
- R1: A request with a negative count (top bit of `req_count` set) ends with a one-cycle `err` and `err_code` = 1, and no command is issued.
- R2: When start + count is greater than `card_blocks` minus the hidden region, the request ends with `err_code` = 2 and no command is issued. The hidden region is 0xF000 blocks on the internal drive and 0 on the other drive. A request that ends exactly at the usable limit is accepted.
- R3: On the internal drive (`req_internal` = 1) the card address of every chunk is the sector number plus 0xF000.
- R4: When `card_high_cap` = 0 the data command argument is the card address times 512. When it is 1, the argument is the card address itself.
- R5: A read chunk uses index 18 and a write chunk uses index 25. Both set `cmd_resp`, `cmd_data` and `cmd_wait_prev`, and only the write sets `cmd_write`. Select is index 7 with argument `{card_rca,16'h0}`. Deselect is index 7 with argument 0. Stop is index 12 with argument 0. Select, deselect and stop request no response.
- R6: With `req_aligned` = 0 each chunk has at most 10 sectors. With `req_aligned` = 1 the whole count is one chunk. Before each data command, `bytcnt_wr` pulses once with `bytcnt` = chunk sectors × 512.
- R7: A data command is issued only after `card_tran` has been sampled high.
- R8: After `data_done` or `data_err` on a write, the stop command waits until `data_busy` is low. A read issues the stop command without waiting.
- R9: If `data_err` arrives during a chunk, then after the stop command `fifo_rst` and `dma_rst` pulse together. No command is issued until both `*_rst_busy` inputs are low. After that the same chunk repeats with the same argument and byte count.
- R10: If a chunk fails again after MAX_RETRY repeats, the request ends with `err_code` = 7 and no deselect. A clean chunk resets the repeat count.
- R11: A `cmd_fail` ends the request at once with `err_code` 3 (select), 4 (data command), 5 (stop) or 6 (deselect). No further command follows.
- R12: `done` and `err` are one-cycle pulses and never high together. `busy` is high from acceptance to the outcome. `req_valid` has no effect while `busy` is high. A zero count selects and then deselects with no data command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write sectors, 0 = read |
| req_internal | input | 1 | 1 = internal drive with hidden region |
| req_aligned | input | 1 | 1 = buffer aligned, one chunk |
| req_start | input | ADDR_W | First sector |
| req_count | input | CNT_W | Sector count, two's complement |
| card_rca | input | 16 | Relative card address |
| card_high_cap | input | 1 | Capacity bit of the card's OCR |
| card_blocks | input | ADDR_W | Total card blocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse, card to be treated as uninitialised |
| err_code | output | 3 | Failure cause, valid with `err` |
| cmd_valid | output | 1 | Command issue pulse |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_resp | output | 1 | Short response expected |
| cmd_data | output | 1 | Data phase expected |
| cmd_write | output | 1 | Data direction is to the card |
| cmd_wait_prev | output | 1 | Wait for previous data to finish |
| cmd_done | input | 1 | Command completed pulse |
| cmd_fail | input | 1 | Command failed pulse |
| card_tran | input | 1 | Card reports transfer state |
| bytcnt_wr | output | 1 | Byte count write pulse |
| bytcnt | output | 32 | Byte count for the chunk |
| data_done | input | 1 | Data transfer over pulse |
| data_err | input | 1 | Data error pulse |
| data_busy | input | 1 | Card programming busy |
| fifo_rst | output | 1 | FIFO reset pulse |
| dma_rst | output | 1 | DMA reset pulse |
| fifo_rst_busy | input | 1 | FIFO reset still in progress |
| dma_rst_busy | input | 1 | DMA reset still in progress |

## Verification
Some properties are checked on every cycle. These are the flag bits of each data command, no stop command while a write is still busy, no command during a FIFO or DMA reset, data commands only after transfer state, and the pulse shape of the outcome. Whether the arguments, byte counts and chunk boundaries are correct depends on the request, so only the bench scenarios can show it. The bench compares every issued command and byte count against a behavioural model. The same holds for the hidden offset, byte addressing, repeated chunks after a data error, the repeat bound, and the error codes for each failing command.

// File: rtl/sdx_xfer_pkg.sv
// Shared types and constants of the SD multi-block transfer sequencer.
// Assumes: command indices follow the SD physical layer numbering.
package sdx_xfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CHECK, ST_SEL_W, ST_CHUNK, ST_TRAN, ST_XCMD_W, ST_DATA,
        ST_BUSY, ST_STOP_W, ST_EVAL, ST_RST_W, ST_DESEL_W
    } seq_state_t;

    typedef enum logic [1:0] {
        CK_SELECT, CK_DESELECT, CK_STOP, CK_XFER
    } cmd_kind_t;

    localparam logic [5:0] IDX_SELECT   = 6'd7;
    localparam logic [5:0] IDX_STOP     = 6'd12;
    localparam logic [5:0] IDX_RD_MULTI = 6'd18;
    localparam logic [5:0] IDX_WR_MULTI = 6'd25;

    localparam int ARG_W        = 32;
    localparam int SECTOR_SHIFT = 9;

    localparam logic [2:0] ERR_NEG_COUNT = 3'd1;
    localparam logic [2:0] ERR_RANGE     = 3'd2;
    localparam logic [2:0] ERR_SELECT    = 3'd3;
    localparam logic [2:0] ERR_XFER_CMD  = 3'd4;
    localparam logic [2:0] ERR_STOP      = 3'd5;
    localparam logic [2:0] ERR_DESELECT  = 3'd6;
    localparam logic [2:0] ERR_RETRIES   = 3'd7;

endpackage

// File: rtl/sdx_xfer_range.sv
// Request range check: flags a negative count and a request whose end
// passes the usable block count (total minus the hidden region).
// Assumes: CNT_W <= ADDR_W + 2; purely combinational.
module sdx_xfer_range #(
    parameter int              ADDR_W      = 32,
    parameter int              CNT_W       = 16,
    parameter logic [ADDR_W-1:0] HIDDEN_BLKS = 'h0000F000
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [CNT_W-1:0]  count,
    input  logic              internal,
    input  logic [ADDR_W-1:0] blocks,
    output logic              negative,
    output logic              over
);
    localparam int SUM_W = ADDR_W + 2;

    logic [SUM_W-1:0] need;

    // End of request including the hidden region, compared with the total.
    always_comb begin
        need     = SUM_W'(start) + SUM_W'(count)
                 + (internal ? SUM_W'(HIDDEN_BLKS) : '0);
        negative = count[CNT_W-1];
        over     = need > SUM_W'(blocks);
    end
endmodule

// File: rtl/sdx_xfer_addr.sv
// Data command argument: adds the hidden offset on the internal drive and
// scales to bytes for standard-capacity cards.
// Assumes: wrap above ARG_W bits is accepted.
module sdx_xfer_addr
    import sdx_xfer_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] HIDDEN_BLKS = 'h0000F000
) (
    input  logic [ADDR_W-1:0] sector,
    input  logic              internal,
    input  logic              high_cap,
    output logic [ARG_W-1:0]  arg
);
    logic [ADDR_W-1:0]              card_addr;
    logic [ADDR_W+SECTOR_SHIFT-1:0] byte_addr;

    // Offset, then pick sector or byte addressing.
    always_comb begin
        card_addr = sector + (internal ? HIDDEN_BLKS : '0);
        byte_addr = {card_addr, {SECTOR_SHIFT{1'b0}}};
        arg       = high_cap ? ARG_W'(card_addr) : ARG_W'(byte_addr);
    end
endmodule

// File: rtl/sdx_xfer_cmdfmt.sv
// Command field formatter: turns a command kind into index, argument and
// flag bits for the shared command-issue interface.
// Assumes: fields are only meaningful while the issue pulse is high.
module sdx_xfer_cmdfmt
    import sdx_xfer_pkg::*;
(
    input  cmd_kind_t        kind,
    input  logic             is_write,
    input  logic [15:0]      rca,
    input  logic [ARG_W-1:0] xfer_arg,
    output logic [5:0]       index,
    output logic [ARG_W-1:0] arg,
    output logic             resp,
    output logic             data,
    output logic             write,
    output logic             wait_prev
);
    // Field selection by kind.
    always_comb begin
        index     = IDX_SELECT;
        arg       = '0;
        resp      = 1'b0;
        data      = 1'b0;
        write     = 1'b0;
        wait_prev = 1'b0;
        case (kind)
            CK_SELECT:   arg = ARG_W'({rca, 16'h0000});
            CK_DESELECT: arg = '0;
            CK_STOP:     index = IDX_STOP;
            CK_XFER: begin
                index     = is_write ? IDX_WR_MULTI : IDX_RD_MULTI;
                arg       = xfer_arg;
                resp      = 1'b1;
                data      = 1'b1;
                write     = is_write;
                wait_prev = 1'b1;
            end
            default: index = IDX_SELECT;
        endcase
    end
endmodule

// File: rtl/sdx_xfer_seq.sv
// SD multi-block transfer sequencer: range check, select, chunked
// read/write commands with byte count, busy wait, stop, error retry
// with FIFO/DMA reset, deselect.
// Assumes: cmd_done/cmd_fail come at least one cycle after cmd_valid;
// the reset-busy inputs rise within one cycle of the reset pulse.
module sdx_xfer_seq
    import sdx_xfer_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                CNT_W         = 16,
    parameter logic [ADDR_W-1:0] HIDDEN_BLKS   = 'h0000F000,
    parameter int                MAX_UNALIGNED = 10,
    parameter int                MAX_RETRY     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_internal,
    input  logic              req_aligned,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [15:0]       card_rca,
    input  logic              card_high_cap,
    input  logic [ADDR_W-1:0] card_blocks,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code,
    output logic              cmd_valid,
    output logic [5:0]        cmd_index,
    output logic [31:0]       cmd_arg,
    output logic              cmd_resp,
    output logic              cmd_data,
    output logic              cmd_write,
    output logic              cmd_wait_prev,
    input  logic              cmd_done,
    input  logic              cmd_fail,
    input  logic              card_tran,
    output logic              bytcnt_wr,
    output logic [31:0]       bytcnt,
    input  logic              data_done,
    input  logic              data_err,
    input  logic              data_busy,
    output logic              fifo_rst,
    output logic              dma_rst,
    input  logic              fifo_rst_busy,
    input  logic              dma_rst_busy
);
    localparam int RTR_W = $clog2(MAX_RETRY + 2);

    seq_state_t        st_q;
    cmd_kind_t         kind_q;
    logic              wr_q, int_q, al_q, hc_q;
    logic [15:0]       rca_q;
    logic [ADDR_W-1:0] start_q, blocks_q;
    logic [CNT_W-1:0]  remain_q, chunk_q;
    logic [RTR_W-1:0]  retries_q;
    logic              saw_err_q;
    logic              cmd_valid_q, done_q, err_q, bytcnt_wr_q, rst_pulse_q;
    logic [2:0]        err_code_q;
    logic [31:0]       bytcnt_q;

    logic              is_neg, is_over;
    logic [ARG_W-1:0]  xfer_arg;
    logic [CNT_W-1:0]  next_chunk;

    sdx_xfer_range #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HIDDEN_BLKS(HIDDEN_BLKS)) u_range (
        .start(start_q), .count(remain_q), .internal(int_q), .blocks(blocks_q),
        .negative(is_neg), .over(is_over)
    );

    sdx_xfer_addr #(.ADDR_W(ADDR_W), .HIDDEN_BLKS(HIDDEN_BLKS)) u_addr (
        .sector(start_q), .internal(int_q), .high_cap(hc_q), .arg(xfer_arg)
    );

    sdx_xfer_cmdfmt u_fmt (
        .kind(kind_q), .is_write(wr_q), .rca(rca_q), .xfer_arg(xfer_arg),
        .index(cmd_index), .arg(cmd_arg), .resp(cmd_resp), .data(cmd_data),
        .write(cmd_write), .wait_prev(cmd_wait_prev)
    );

    // Chunk size: whole remainder when aligned, else capped.
    always_comb begin
        if (al_q || remain_q < CNT_W'(MAX_UNALIGNED))
            next_chunk = remain_q;
        else
            next_chunk = CNT_W'(MAX_UNALIGNED);
    end

    // Sequencer state, request context and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            kind_q      <= CK_SELECT;
            wr_q        <= 1'b0;
            int_q       <= 1'b0;
            al_q        <= 1'b0;
            hc_q        <= 1'b0;
            rca_q       <= '0;
            start_q     <= '0;
            blocks_q    <= '0;
            remain_q    <= '0;
            chunk_q     <= '0;
            retries_q   <= '0;
            saw_err_q   <= 1'b0;
            cmd_valid_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            err_code_q  <= '0;
            bytcnt_wr_q <= 1'b0;
            bytcnt_q    <= '0;
            rst_pulse_q <= 1'b0;
        end else begin
            cmd_valid_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            bytcnt_wr_q <= 1'b0;
            rst_pulse_q <= 1'b0;
            if (data_err && (st_q == ST_DATA || st_q == ST_BUSY ||
                             st_q == ST_STOP_W || st_q == ST_XCMD_W))
                saw_err_q <= 1'b1;
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    wr_q      <= req_write;
                    int_q     <= req_internal;
                    al_q      <= req_aligned;
                    hc_q      <= card_high_cap;
                    rca_q     <= card_rca;
                    start_q   <= req_start;
                    remain_q  <= req_count;
                    blocks_q  <= card_blocks;
                    retries_q <= '0;
                    st_q      <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (is_neg || is_over) begin
                        err_q      <= 1'b1;
                        err_code_q <= is_neg ? ERR_NEG_COUNT : ERR_RANGE;
                        st_q       <= ST_IDLE;
                    end else begin
                        cmd_valid_q <= 1'b1;
                        kind_q      <= CK_SELECT;
                        st_q        <= ST_SEL_W;
                    end
                end
                ST_SEL_W: begin
                    if (cmd_fail) begin
                        err_q <= 1'b1; err_code_q <= ERR_SELECT; st_q <= ST_IDLE;
                    end else if (cmd_done) begin
                        if (remain_q == '0) begin
                            cmd_valid_q <= 1'b1;
                            kind_q      <= CK_DESELECT;
                            st_q        <= ST_DESEL_W;
                        end else begin
                            st_q <= ST_CHUNK;
                        end
                    end
                end
                ST_CHUNK: begin
                    chunk_q     <= next_chunk;
                    bytcnt_q    <= 32'(next_chunk) << SECTOR_SHIFT;
                    bytcnt_wr_q <= 1'b1;
                    saw_err_q   <= 1'b0;
                    st_q        <= ST_TRAN;
                end
                ST_TRAN: if (card_tran) begin
                    cmd_valid_q <= 1'b1;
                    kind_q      <= CK_XFER;
                    st_q        <= ST_XCMD_W;
                end
                ST_XCMD_W: begin
                    if (cmd_fail) begin
                        err_q <= 1'b1; err_code_q <= ERR_XFER_CMD; st_q <= ST_IDLE;
                    end else if (cmd_done) begin
                        st_q <= ST_DATA;
                    end
                end
                ST_DATA: if (data_done || data_err) begin
                    if (wr_q) begin
                        st_q <= ST_BUSY;
                    end else begin
                        cmd_valid_q <= 1'b1;
                        kind_q      <= CK_STOP;
                        st_q        <= ST_STOP_W;
                    end
                end
                ST_BUSY: if (!data_busy) begin
                    cmd_valid_q <= 1'b1;
                    kind_q      <= CK_STOP;
                    st_q        <= ST_STOP_W;
                end
                ST_STOP_W: begin
                    if (cmd_fail) begin
                        err_q <= 1'b1; err_code_q <= ERR_STOP; st_q <= ST_IDLE;
                    end else if (cmd_done) begin
                        st_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (saw_err_q) begin
                        if (retries_q == RTR_W'(MAX_RETRY)) begin
                            err_q <= 1'b1; err_code_q <= ERR_RETRIES; st_q <= ST_IDLE;
                        end else begin
                            rst_pulse_q <= 1'b1;
                            retries_q   <= retries_q + 1'b1;
                            st_q        <= ST_RST_W;
                        end
                    end else begin
                        start_q   <= start_q + ADDR_W'(chunk_q);
                        remain_q  <= remain_q - chunk_q;
                        retries_q <= '0;
                        if (remain_q == chunk_q) begin
                            cmd_valid_q <= 1'b1;
                            kind_q      <= CK_DESELECT;
                            st_q        <= ST_DESEL_W;
                        end else begin
                            st_q <= ST_CHUNK;
                        end
                    end
                end
                ST_RST_W: if (!fifo_rst_busy && !dma_rst_busy) st_q <= ST_CHUNK;
                ST_DESEL_W: begin
                    if (cmd_fail) begin
                        err_q <= 1'b1; err_code_q <= ERR_DESELECT; st_q <= ST_IDLE;
                    end else if (cmd_done) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign err_code  = err_code_q;
    assign cmd_valid = cmd_valid_q;
    assign bytcnt_wr = bytcnt_wr_q;
    assign bytcnt    = bytcnt_q;
    assign fifo_rst  = rst_pulse_q;
    assign dma_rst   = rst_pulse_q;
endmodule

// File: rtl/sdx_xfer_seq_chk.sv
// Protocol checker for the transfer sequencer, bound to every instance.
// Assumes: observes ports only; tracks the accepted direction itself.
module sdx_xfer_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [2:0] err_code,
    input logic       cmd_valid,
    input logic [5:0] cmd_index,
    input logic       cmd_resp,
    input logic       cmd_data,
    input logic       cmd_write,
    input logic       cmd_wait_prev,
    input logic       card_tran,
    input logic       data_busy,
    input logic       fifo_rst,
    input logic       fifo_rst_busy,
    input logic       dma_rst_busy
);
    logic wr_seen;

    // Direction of the request accepted last.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wr_seen <= 1'b0;
        else if (req_valid && !busy)  wr_seen <= req_write;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R12
    AST_BUSY_ENDS_WITH_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err)); // R12
    AST_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_index == 6'd25) |-> (cmd_resp && cmd_data && cmd_write && cmd_wait_prev)); // R5
    AST_RD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_index == 6'd18) |-> (cmd_resp && cmd_data && !cmd_write && cmd_wait_prev)); // R5
    AST_STOP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_index == 6'd12 && wr_seen) |-> !data_busy); // R8
    AST_XFER_IN_TRAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_index == 6'd18 || cmd_index == 6'd25)) |-> $past(card_tran)); // R7
    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rst || fifo_rst_busy || dma_rst_busy) |-> !cmd_valid); // R9
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 3'd0)); // R11
endmodule

bind sdx_xfer_seq sdx_xfer_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_resp(cmd_resp),
    .cmd_data(cmd_data), .cmd_write(cmd_write), .cmd_wait_prev(cmd_wait_prev),
    .card_tran(card_tran), .data_busy(data_busy), .fifo_rst(fifo_rst),
    .fifo_rst_busy(fifo_rst_busy), .dma_rst_busy(dma_rst_busy)
);

// File: tb/tb_sdx_xfer_seq.sv
`timescale 1ns/1ps
module tb_sdx_xfer_seq;
    localparam int MAXR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_internal = 0, req_aligned = 0;
    logic [31:0] req_start = 0;
    logic [15:0] req_count = 0;
    logic [15:0] card_rca = 16'hB5A3;
    logic        card_high_cap = 0;
    logic [31:0] card_blocks = 0;
    logic        busy, done, err;
    logic [2:0]  err_code;
    logic        cmd_valid;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        cmd_resp, cmd_data, cmd_write, cmd_wait_prev;
    logic        cmd_done = 0, cmd_fail = 0, card_tran = 1;
    logic        bytcnt_wr;
    logic [31:0] bytcnt;
    logic        data_done = 0, data_err = 0, data_busy = 0;
    logic        fifo_rst, dma_rst;
    logic        fifo_rst_busy = 0, dma_rst_busy = 0;

    sdx_xfer_seq #(.MAX_RETRY(MAXR)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_internal(req_internal), .req_aligned(req_aligned), .req_start(req_start),
        .req_count(req_count), .card_rca(card_rca), .card_high_cap(card_high_cap),
        .card_blocks(card_blocks), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_resp(cmd_resp), .cmd_data(cmd_data),
        .cmd_write(cmd_write), .cmd_wait_prev(cmd_wait_prev), .cmd_done(cmd_done),
        .cmd_fail(cmd_fail), .card_tran(card_tran), .bytcnt_wr(bytcnt_wr),
        .bytcnt(bytcnt), .data_done(data_done), .data_err(data_err),
        .data_busy(data_busy), .fifo_rst(fifo_rst), .dma_rst(dma_rst),
        .fifo_rst_busy(fifo_rst_busy), .dma_rst_busy(dma_rst_busy)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [41:0] exp_cmd[$];
    logic [31:0] exp_bc[$];
    int  fail_at = -1, cmd_seen = 0, err_budget = 0;
    int  data_cnt = 0, busy_cnt = 0, rst_cnt = 0, tran_hold = 0;
    bit  wr_mode = 0, pend = 0;
    logic [5:0] pend_idx = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [41:0] mk(input logic [5:0] i, input logic [31:0] a,
                                       input bit r, input bit d, input bit w, input bit p);
        return {i, a, r, d, w, p};
    endfunction

    // Card / command engine / data path responder.
    always @(negedge clk) begin
        cmd_done = 0; cmd_fail = 0; data_done = 0; data_err = 0;
        if (busy_cnt > 0) busy_cnt--;
        if (data_cnt > 0) begin
            data_cnt--;
            if (data_cnt == 0) begin
                if (err_budget > 0) begin data_err = 1; err_budget--; end
                else data_done = 1;
                if (wr_mode) busy_cnt = 4;
            end
        end
        data_busy = (busy_cnt > 0);
        if (pend) begin
            if (cmd_seen == fail_at) cmd_fail = 1;
            else begin
                cmd_done = 1;
                if (pend_idx == 6'd18 || pend_idx == 6'd25) data_cnt = 3;
            end
            cmd_seen++;
            pend = 0;
        end
        if (cmd_valid) begin pend = 1; pend_idx = cmd_index; end
        if (rst_cnt > 0) rst_cnt--;
        if (fifo_rst) rst_cnt = 3;
        fifo_rst_busy = (rst_cnt > 0);
        dma_rst_busy  = (rst_cnt > 1);
        if (tran_hold > 0) tran_hold--;
        card_tran = (tran_hold == 0);
    end

    // Compare every issued command and byte count against the model.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_cmd.size() == 0)
                chk(0, "R12", "unexpected command", cmd_index, 0);
            else begin
                logic [41:0] e, g;
                e = exp_cmd.pop_front();
                g = {cmd_index, cmd_arg, cmd_resp, cmd_data, cmd_write, cmd_wait_prev};
                if (cmd_index == 6'd18 || cmd_index == 6'd25) begin
                    chk(g == e, "R4", "data command word", g, e);
                    chk(card_tran, "R7", "data command outside TRAN", card_tran, 1);
                end else
                    chk(g == e, "R5", "control command word", g, e);
                if (cmd_index == 6'd12 && wr_mode)
                    chk(!data_busy, "R8", "stop while busy", data_busy, 0);
                if (fifo_rst_busy || dma_rst_busy)
                    chk(0, "R9", "command during reset", 1, 0);
            end
        end
        if (rst_n && bytcnt_wr) begin
            if (exp_bc.size() == 0)
                chk(0, "R6", "unexpected byte count", bytcnt, 0);
            else begin
                logic [31:0] b;
                b = exp_bc.pop_front();
                chk(bytcnt == b, "R6", "byte count", bytcnt, b);
            end
        end
        if (rst_n && fifo_rst)
            chk(dma_rst, "R9", "resets not paired", dma_rst, 1);
    end

    task automatic run(input bit wr, input bit intl, input bit al, input bit hc,
                       input int start, input int count, input logic [31:0] blocks,
                       input int errs, input int fail_i, input int twait, input bit poke);
        logic [41:0] full[$];
        logic [31:0] hid, a;
        int code, rem, s, rtr, e, ch, nx;
        string tag;
        hid = intl ? 32'hF000 : 32'h0;
        code = 0;
        if (count < 0) code = 1;
        else if (longint'(start) + count + hid > longint'(blocks)) code = 2;
        else begin
            full.push_back(mk(6'd7, {card_rca, 16'h0}, 0, 0, 0, 0));
            rem = count; s = start; rtr = 0; e = errs;
            while (rem > 0) begin
                ch = al ? rem : (rem < 10 ? rem : 10);
                a  = 32'(s) + hid;
                if (!hc) a = a * 512;
                full.push_back(mk(wr ? 6'd25 : 6'd18, a, 1, 1, wr, 1));
                full.push_back(mk(6'd12, 0, 0, 0, 0, 0));
                if (e > 0) begin
                    e--;
                    if (rtr == MAXR) begin code = 7; break; end
                    rtr++;
                end else begin
                    s += ch; rem -= ch; rtr = 0;
                end
            end
            if (code == 0) full.push_back(mk(6'd7, 0, 0, 0, 0, 0));
            if (fail_i >= 0 && fail_i < full.size()) begin
                while (full.size() > fail_i + 1) void'(full.pop_back());
                case (full[fail_i][41:36])
                    6'd7:    code = (fail_i == 0) ? 3 : 6;
                    6'd12:   code = 5;
                    default: code = 4;
                endcase
            end
        end
        // Byte counts: one per data command in the expected stream.
        rem = count; s = 0; e = errs; rtr = 0;
        foreach (full[k]) begin
            if (full[k][41:36] == 6'd18 || full[k][41:36] == 6'd25) begin
                ch = al ? rem : (rem < 10 ? rem : 10);
                exp_bc.push_back(32'(ch) * 512);
                if (e > 0) e--; else rem -= ch;
            end
        end
        foreach (full[k]) exp_cmd.push_back(full[k]);
        @(negedge clk);
        fail_at = fail_i; cmd_seen = 0; err_budget = errs; wr_mode = wr;
        tran_hold = twait;
        req_write = wr; req_internal = intl; req_aligned = al; card_high_cap = hc;
        req_start = 32'(start); req_count = 16'(count); card_blocks = blocks;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        nx = 0;
        while (!(done || err) && nx < 5000) begin
            @(negedge clk);
            nx++;
            if (poke && nx == 2) begin req_valid = 1; req_count = 16'hFFFF; end
            else req_valid = 0;
        end
        req_valid = 0;
        tag = (code == 0) ? "R12" : (code == 1) ? "R1" : (code == 2) ? "R2" :
              (code == 7) ? "R10" : "R11";
        if (code == 0) chk(done && !err, tag, "outcome done", {done, err}, 2'b10);
        else chk(err && !done && err_code == 3'(code), tag, "error code",
                 {err, err_code}, {1'b1, 3'(code)});
        @(negedge clk);
        chk(!done && !err && !busy, "R12", "outcome not single pulse", {busy, done, err}, 0);
        repeat (8) @(negedge clk);
        chk(exp_cmd.size() == 0, tag, "commands missing", exp_cmd.size(), 0);
        chk(exp_bc.size() == 0, "R6", "byte counts missing", exp_bc.size(), 0);
        exp_cmd.delete(); exp_bc.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid && !bytcnt_wr && !fifo_rst,
            "R12", "reset state", {busy, done, err, cmd_valid}, 0);
        // R3 R4 R5 R6: internal drive, byte addressing, aligned read as one chunk
        run(0, 1, 1, 0, 5, 3, 32'h10000, 0, -1, 0, 0);
        // R6 R7 R8: unaligned write split 10/10/5, TRAN held low at first
        run(1, 0, 0, 1, 100, 25, 1000, 0, -1, 12, 0);
        // R2: ends exactly at the usable limit, accepted
        run(0, 1, 1, 1, 7, 3, 32'hF000 + 10, 0, -1, 0, 0);
        // R2: one block past the limit
        run(0, 1, 1, 1, 8, 3, 32'hF000 + 10, 0, -1, 0, 0);
        // R1: negative count
        run(0, 0, 1, 1, 0, -2, 1000, 0, -1, 0, 0);
        // R9: one data error, chunk repeated at the same address
        run(0, 0, 0, 1, 40, 12, 1000, 1, -1, 0, 0);
        // R10: error on every attempt, repeat bound reached
        run(1, 0, 1, 0, 3, 4, 1000, MAXR + 1, -1, 0, 0);
        // R11: select, data command, stop and deselect failures
        run(0, 0, 1, 1, 0, 2, 1000, 0, 0, 0, 0);
        run(0, 0, 1, 1, 0, 2, 1000, 0, 1, 0, 0);
        run(1, 0, 1, 1, 0, 2, 1000, 0, 2, 0, 0);
        run(0, 0, 1, 1, 0, 2, 1000, 0, 3, 0, 0);
        // R12: zero count, and a request poked while busy is ignored
        run(0, 0, 0, 1, 9, 0, 1000, 0, -1, 0, 1);
        run(1, 1, 0, 0, 2, 11, 32'h10000, 0, -1, 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule